// File: doc/BRIEF.md
# Integer Execute Unit

This block is the arithmetic stage of a 32-bit RISC pipeline. Each operation arrives with both register operands already read, a 5-bit shift immediate, a 16-bit immediate, an operation code and the index of the destination register. The block returns the result together with a write enable for the register file. Memory access and register storage are handled elsewhere.

Most operations finish in one cycle. These are add, subtract, low and high multiply, the bitwise operations with their immediate and upper-half immediate forms, shifts, rotates and compares. Signed and unsigned divide use a restoring divider that takes one cycle per quotient bit. A zero divisor does not trap, and neither does the signed overflow case: both give a defined quotient.

The input side is a valid/ready stream. An operation moves when `in_valid` and `in_ready` are both high at a clock edge. Once `in_valid` is raised, the operation and all its fields stay constant until that transfer happens. The output side is also a valid/ready stream. While `out_valid` is high and `out_ready` is low, the result, destination and write enable hold their values. `in_ready` drops while a divide is in progress, and also while a held result has not yet been taken. As a result, results always leave in the order their operations arrived.

Top module: `exu_core`

## Requirements
- R1: ADD, SUB and MUL return the low 32 bits of a+b, a-b and a*b. Overflow wraps silently.
- R2: MULHSS, MULHUU and MULHSU return the upper 32 bits of the 64-bit product. The operands are treated as signed×signed, unsigned×unsigned and signed A × unsigned B respectively.
- R3: AND, OR, XOR and NOR combine A with B.
  - ANDI, ORI and XORI combine A with the 16-bit immediate zero-extended.
  - ANDHI, ORHI and XORHI combine A with the immediate placed in bits 31:16, with zeros below.
- R4: ADDI, MULI and the signed compare immediates (CGEI, CLTI, CNEI, CEQI) sign-extend bit 15 of the immediate. The unsigned compare immediates (CGEUI, CLTUI) zero-extend it.
- R5: SLL, SRL, SRA, ROL and ROR shift or rotate A by B[4:0] only, ignoring the upper bits of B. SLLI, SRLI, SRAI and ROLI use the 5-bit immediate instead. SRA and SRAI fill with the sign bit.
- R6: Compares test A against the second operand and return exactly 1 when true and 0 when false. The tests are >=, <, != and ==, with >= and < in both signed and unsigned forms.
- R7: DIVU returns the unsigned quotient. A zero divisor is treated as 1, so the quotient equals A.
- R8: DIV returns the signed quotient truncated toward zero. When B is 0, or when A is 0x80000000 and B is 0xFFFFFFFF, the divisor is treated as 1 and the quotient equals A.
- R9: `out_we` is high only while `out_valid` is high and `out_dest` is non-zero. A result addressed to register 0 is delivered with `out_we` low, so it never writes.
- R10: A result waiting with `out_ready` low holds `out_data`, `out_dest` and `out_we`. `in_ready` is low throughout a divide.
- R11: A non-divide result is valid in the cycle after its operation is accepted. A divide result is valid 33 cycles later than that (W+1).
- R12: During and right after reset, `out_valid` and `out_we` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted at this edge if offered |
| in_op | input | 6 | Operation code (`exu_op_e` in `exu_pkg`) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B (register form) |
| in_imm5 | input | 5 | Shift/rotate immediate |
| in_imm16 | input | 16 | 16-bit immediate |
| in_dest | input | 5 | Destination register index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_data | output | 32 | Result |
| out_we | output | 1 | Register file write enable |
| out_dest | output | 5 | Destination register index of the result |

## Verification
The assertions rely on the producer keeping every field steady while `in_valid` waits for `in_ready`. They also rely on `in_op` carrying only the defined operation codes. The bench drives only codes taken from the package enumeration. Its send task raises the fields once and leaves them untouched until it has seen `in_ready` high before an edge, and it drops `in_valid` right after that edge. `out_ready` is driven at random so that results are held under back-pressure. The bench also deliberately starts divides at moments when a previous result is still waiting.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [5:0] {
    OP_ADD, OP_SUB, OP_MUL, OP_MULHSS, OP_MULHUU, OP_MULHSU,
    OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
    OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI,
    OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
    OP_ADDI, OP_MULI, OP_ANDI, OP_ORI, OP_XORI,
    OP_ANDHI, OP_ORHI, OP_XORHI,
    OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI,
    OP_DIV, OP_DIVU
  } exu_op_e;

  localparam int OP_COUNT = 41;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  imm5,
  input  logic [15:0]    imm16,
  output logic [W-1:0]   res,
  output logic           is_cmp
);
  localparam int W2 = 2 * W;

  logic [W-1:0]  imm_s, imm_z, imm_h, opb;
  logic [SW-1:0] sh;
  logic          sh_imm, sa, sb, is_ror;
  logic [W2-1:0] ma, mb, prod;
  logic [W-1:0]  rot;
  logic          lt_s, lt_u, eq;
  int            ramt;

  assign imm_s = {{(W-16){imm16[15]}}, imm16};
  assign imm_z = {{(W-16){1'b0}}, imm16};
  assign imm_h = imm_z << 16;

  // second operand selection
  always_comb begin
    unique case (op)
      OP_ADDI, OP_MULI, OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI: opb = imm_s;
      OP_ANDI, OP_ORI, OP_XORI, OP_CGEUI, OP_CLTUI:         opb = imm_z;
      OP_ANDHI, OP_ORHI, OP_XORHI:                          opb = imm_h;
      default:                                              opb = b;
    endcase
  end

  assign sh_imm = (op == OP_SLLI) || (op == OP_SRLI) || (op == OP_SRAI) || (op == OP_ROLI);
  assign sh     = sh_imm ? imm5 : opb[SW-1:0];

  // one shared multiplier, operand extension picks the signedness
  assign sa   = (op == OP_MULHSS) || (op == OP_MULHSU);
  assign sb   = (op == OP_MULHSS);
  assign ma   = {{W{sa & a[W-1]}}, a};
  assign mb   = {{W{sb & opb[W-1]}}, opb};
  assign prod = ma * mb;

  // rotator: a right rotate is a left rotate by W - amount
  assign is_ror = (op == OP_ROR);
  always_comb begin
    ramt = is_ror ? ((W - int'(sh)) % W) : int'(sh);
    for (int i = 0; i < W; i++) rot[i] = a[(i + W - ramt) % W];
  end

  assign lt_s = $signed(a) < $signed(opb);
  assign lt_u = a < opb;
  assign eq   = (a == opb);

  always_comb begin
    is_cmp = 1'b0;
    res    = '0;
    unique case (op)
      OP_ADD, OP_ADDI:                res = a + opb;
      OP_SUB:                         res = a - opb;
      OP_MUL, OP_MULI:                res = prod[W-1:0];
      OP_MULHSS, OP_MULHUU, OP_MULHSU: res = prod[W2-1:W];
      OP_AND, OP_ANDI, OP_ANDHI:      res = a & opb;
      OP_OR, OP_ORI, OP_ORHI:         res = a | opb;
      OP_XOR, OP_XORI, OP_XORHI:      res = a ^ opb;
      OP_NOR:                         res = ~(a | opb);
      OP_SLL, OP_SLLI:                res = a << sh;
      OP_SRL, OP_SRLI:                res = a >> sh;
      OP_SRA, OP_SRAI:                res = $signed(a) >>> sh;
      OP_ROL, OP_ROLI, OP_ROR:        res = rot;
      OP_CGE, OP_CGEI:   begin is_cmp = 1'b1; res = {{(W-1){1'b0}}, ~lt_s}; end
      OP_CLT, OP_CLTI:   begin is_cmp = 1'b1; res = {{(W-1){1'b0}},  lt_s}; end
      OP_CNE, OP_CNEI:   begin is_cmp = 1'b1; res = {{(W-1){1'b0}}, ~eq};   end
      OP_CEQ, OP_CEQI:   begin is_cmp = 1'b1; res = {{(W-1){1'b0}},  eq};   end
      OP_CGEU, OP_CGEUI: begin is_cmp = 1'b1; res = {{(W-1){1'b0}}, ~lt_u}; end
      OP_CLTU, OP_CLTUI: begin is_cmp = 1'b1; res = {{(W-1){1'b0}},  lt_u}; end
      default:                        res = '0;
    endcase
  end

endmodule

// File: rtl/exu_div.sv
module exu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  dv_fix, mag_a, mag_b;
  logic          neg_d;
  logic [W-1:0]  rem, quo, dv;
  logic          neg_q;
  logic [CW-1:0] cnt;
  logic [W:0]    rem_sh;
  logic          fits;
  logic [W-1:0]  diff;

  // corner cases: zero divisor and most-negative / -1 both divide by one
  always_comb begin
    dv_fix = divisor;
    if ((divisor == '0) ||
        (signed_mode && (dividend == MIN_NEG) && (divisor == '1)))
      dv_fix = {{(W-1){1'b0}}, 1'b1};
    neg_d = signed_mode && (dividend[W-1] ^ dv_fix[W-1]);
    mag_a = (signed_mode && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
    mag_b = (signed_mode && dv_fix[W-1])   ? (~dv_fix + 1'b1)   : dv_fix;
  end

  // one restoring step per cycle
  assign rem_sh = {rem, quo[W-1]};
  assign fits   = rem_sh >= {1'b0, dv};
  assign diff   = rem_sh[W-1:0] - dv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      quo   <= '0;
      dv    <= '0;
      neg_q <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        quo   <= mag_a;
        dv    <= mag_b;
        neg_q <= neg_d;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        rem <= fits ? diff : rem_sh[W-1:0];
        quo <= {quo[W-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = neg_q ? (~quo + 1'b1) : quo;

  // R10: no new divide is launched while one runs
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: completion only ends a running divide
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int W      = 32,
  parameter int DEST_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [5:0]           in_op,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic [$clog2(W)-1:0] in_imm5,
  input  logic [15:0]          in_imm16,
  input  logic [DEST_W-1:0]    in_dest,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data,
  output logic                 out_we,
  output logic [DEST_W-1:0]    out_dest
);
  localparam int SW = $clog2(W);

  exu_op_e             op;
  logic                is_div, accept, div_start;
  logic                div_busy, div_done;
  logic [W-1:0]        alu_res, div_q;
  logic                alu_cmp, out_cmp;
  logic [DEST_W-1:0]   pend_dest;

  assign op        = exu_op_e'(in_op);
  assign is_div    = (op == OP_DIV) || (op == OP_DIVU);
  assign in_ready  = !div_busy && !div_done && (!out_valid || out_ready);
  assign accept    = in_valid && in_ready;
  assign div_start = accept && is_div;

  exu_alu #(.W(W), .SW(SW)) u_alu (
    .op     (op),
    .a      (in_a),
    .b      (in_b),
    .imm5   (in_imm5),
    .imm16  (in_imm16),
    .res    (alu_res),
    .is_cmp (alu_cmp)
  );

  exu_div #(.W(W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (div_start),
    .signed_mode (op == OP_DIV),
    .dividend    (in_a),
    .divisor     (in_b),
    .busy        (div_busy),
    .done        (div_done),
    .quotient    (div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_dest <= '0;
    else if (div_start) pend_dest <= in_dest;
  end

  // output register: single-cycle results, divide results, or drain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
      out_we    <= 1'b0;
      out_cmp   <= 1'b0;
    end else if (accept && !is_div) begin
      out_valid <= 1'b1;
      out_data  <= alu_res;
      out_dest  <= in_dest;
      out_we    <= (in_dest != '0);
      out_cmp   <= alu_cmp;
    end else if (div_done) begin
      out_valid <= 1'b1;
      out_data  <= div_q;
      out_dest  <= pend_dest;
      out_we    <= (pend_dest != '0);
      out_cmp   <= 1'b0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
    end
  end

  // R10: a stalled result does not move
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_dest) && $stable(out_we)));

  // R9: no write is offered for register 0 or without a result
  a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_valid && (out_dest != '0)));

  // R6: compare results are 0 or 1
  a_r6_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmp) |-> (out_data[W-1:1] == '0));

endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
  import exu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [4:0]  in_imm5 = '0;
  logic [15:0] in_imm16 = '0;
  logic [4:0]  in_dest = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_we;
  logic [4:0]  out_dest;

  always #5 clk = ~clk;

  exu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm5(in_imm5),
    .in_imm16(in_imm16), .in_dest(in_dest), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_we(out_we),
    .out_dest(out_dest)
  );

  typedef struct {
    logic [31:0] data;
    logic        we;
    logic [4:0]  dest;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails = 0;
  bit          rdy_rand = 1'b0;
  bit          finished = 1'b0;
  bit          hold_pend = 1'b0;
  logic [31:0] hold_d;
  logic        hold_we;
  logic [4:0]  hold_dest;

  function automatic logic [31:0] model(exu_op_e op, logic [31:0] a, logic [31:0] b,
                                        logic [4:0] i5, logic [15:0] i16);
    logic [31:0]        se, ze, hi;
    logic signed [63:0] pss, psu;
    logic [63:0]        puu;
    int                 s;
    se  = {{16{i16[15]}}, i16};
    ze  = {16'h0, i16};
    hi  = {i16, 16'h0};
    pss = $signed(a) * $signed(b);
    psu = $signed(a) * $signed({1'b0, b});
    puu = {32'h0, a} * {32'h0, b};
    s   = int'(b[4:0]);
    case (op)
      OP_ADD:    return a + b;
      OP_SUB:    return a - b;
      OP_MUL:    return puu[31:0];
      OP_MULHSS: return pss[63:32];
      OP_MULHUU: return puu[63:32];
      OP_MULHSU: return psu[63:32];
      OP_AND:    return a & b;
      OP_OR:     return a | b;
      OP_XOR:    return a ^ b;
      OP_NOR:    return ~(a | b);
      OP_SLL:    return a << s;
      OP_SRL:    return a >> s;
      OP_SRA:    return $signed(a) >>> s;
      OP_ROL:    return (a << s) | (a >> (32 - s));
      OP_ROR:    return (a >> s) | (a << (32 - s));
      OP_SLLI:   return a << i5;
      OP_SRLI:   return a >> i5;
      OP_SRAI:   return $signed(a) >>> i5;
      OP_ROLI:   return (a << i5) | (a >> (32 - int'(i5)));
      OP_CGE:    return {31'h0, $signed(a) >= $signed(b)};
      OP_CLT:    return {31'h0, $signed(a) < $signed(b)};
      OP_CNE:    return {31'h0, a != b};
      OP_CEQ:    return {31'h0, a == b};
      OP_CGEU:   return {31'h0, a >= b};
      OP_CLTU:   return {31'h0, a < b};
      OP_ADDI:   return a + se;
      OP_MULI:   return a * se;
      OP_ANDI:   return a & ze;
      OP_ORI:    return a | ze;
      OP_XORI:   return a ^ ze;
      OP_ANDHI:  return a & hi;
      OP_ORHI:   return a | hi;
      OP_XORHI:  return a ^ hi;
      OP_CGEI:   return {31'h0, $signed(a) >= $signed(se)};
      OP_CLTI:   return {31'h0, $signed(a) < $signed(se)};
      OP_CNEI:   return {31'h0, a != se};
      OP_CEQI:   return {31'h0, a == se};
      OP_CGEUI:  return {31'h0, a >= ze};
      OP_CLTUI:  return {31'h0, a < ze};
      OP_DIVU:   return (b == 0) ? a : a / b;
      OP_DIV: begin
        if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return a;
        return $signed(a) / $signed(b);
      end
      default:   return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(exu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL:                       return "R1";
      OP_MULHSS, OP_MULHUU, OP_MULHSU:              return "R2";
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_ANDI, OP_ORI, OP_XORI,
      OP_ANDHI, OP_ORHI, OP_XORHI:                  return "R3";
      OP_ADDI, OP_MULI, OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI,
      OP_CGEUI, OP_CLTUI:                           return "R4";
      OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
      OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI:           return "R5";
      OP_DIVU:                                      return "R7";
      OP_DIV:                                       return "R8";
      default:                                      return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: offer one operation, record its expected result on acceptance
  task automatic send(exu_op_e op, logic [31:0] a, logic [31:0] b, logic [4:0] i5,
                      logic [15:0] i16, logic [4:0] dest, string tag, logic [31:0] want);
    exp_t e;
    e.data = want;
    e.we   = (dest != 0);
    e.dest = dest;
    e.tag  = tag;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    in_imm5 = i5; in_imm16 = i16; in_dest = dest;
    while (!in_ready) @(negedge clk);
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_m(exu_op_e op, logic [31:0] a, logic [31:0] b, logic [4:0] i5,
                        logic [15:0] i16, logic [4:0] dest);
    send(op, a, b, i5, i16, dest, tag_of(op), model(op, a, b, i5, i16));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'($urandom_range(0, 20));
      default: return $urandom;
    endcase
  endfunction

  // consumer back-pressure, changed well away from the sampling edge
  always @(posedge clk) begin
    #2 out_ready <= rdy_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor: compare each delivered result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hold_pend) begin
        hold_pend = 1'b0;
        check("R10 hold", {out_valid, out_we, out_dest, 25'h0} ^ {1'b0, 31'h0} ^ {out_data == hold_d, 31'h0},
              {1'b1, hold_we, hold_dest, 25'h0} ^ {1'b0, 31'h0} ^ {1'b1, 31'h0});
      end
      if (out_valid) begin
        if (!out_ready) begin
          hold_pend = 1'b1;
          hold_d    = out_data;
          hold_we   = out_we;
          hold_dest = out_dest;
        end else if (sb.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R10 unexpected result actual=%h expected=none", out_data);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, out_data, e.data);
          check({e.tag, " R9 we/dest"}, {26'h0, out_we, out_dest}, {26'h0, e.we, e.dest});
        end
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R12: reset state
    check("R12 in reset", {29'h0, out_valid, out_we, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset", {29'h0, out_valid, out_we, in_ready}, 32'h1);

    // R1
    send(OP_ADD, 32'd5, 32'hFFFF_FFFD, 0, 0, 5'd3, "R1 add", 32'd2);
    send(OP_SUB, 32'd0, 32'd1, 0, 0, 5'd3, "R1 sub", 32'hFFFF_FFFF);
    send(OP_MUL, 32'h0001_0000, 32'h0001_0000, 0, 0, 5'd4, "R1 mul wrap", 32'h0);
    // R2
    send(OP_MULHSS, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 5'd4, "R2 ss", 32'h0);
    send(OP_MULHUU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 5'd4, "R2 uu", 32'hFFFF_FFFE);
    send(OP_MULHSU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 5'd4, "R2 su", 32'hFFFF_FFFF);
    // R3
    send(OP_NOR, 32'h0, 32'h0, 0, 0, 5'd6, "R3 nor", 32'hFFFF_FFFF);
    send(OP_ANDI, 32'hFFFF_FFFF, 32'h0, 0, 16'h8001, 5'd6, "R3 andi zext", 32'h0000_8001);
    send(OP_ORHI, 32'h0, 32'h0, 0, 16'hABCD, 5'd6, "R3 orhi", 32'hABCD_0000);
    send(OP_ANDHI, 32'hFFFF_FFFF, 32'h0, 0, 16'h00FF, 5'd6, "R3 andhi", 32'h00FF_0000);
    // R4
    send(OP_ADDI, 32'h0, 32'h0, 0, 16'hFFFF, 5'd7, "R4 addi sext", 32'hFFFF_FFFF);
    send(OP_CLTUI, 32'd5, 32'h0, 0, 16'hFFFF, 5'd7, "R4 cltui zext", 32'd1);
    send(OP_CLTI, 32'd5, 32'h0, 0, 16'hFFFF, 5'd7, "R4 clti sext", 32'd0);
    // R5
    send(OP_SLL, 32'd1, 32'h21, 0, 0, 5'd8, "R5 sll low bits", 32'd2);
    send(OP_SRA, 32'h8000_0000, 32'd31, 0, 0, 5'd8, "R5 sra", 32'hFFFF_FFFF);
    send(OP_ROR, 32'd1, 32'hFFFF_FFE1, 0, 0, 5'd8, "R5 ror", 32'h8000_0000);
    send(OP_ROLI, 32'hF000_0000, 32'd0, 5'd4, 0, 5'd8, "R5 roli", 32'h0000_000F);
    // R6
    send(OP_CGE, 32'hFFFF_FFFF, 32'h0, 0, 0, 5'd9, "R6 cge", 32'd0);
    send(OP_CGEU, 32'hFFFF_FFFF, 32'h0, 0, 0, 5'd9, "R6 cgeu", 32'd1);
    send(OP_CNE, 32'd7, 32'd7, 0, 0, 5'd9, "R6 cne", 32'd0);
    send(OP_CEQ, 32'd7, 32'd7, 0, 0, 5'd9, "R6 ceq", 32'd1);
    // R7
    send(OP_DIVU, 32'd7, 32'd0, 0, 0, 5'd10, "R7 divu by zero", 32'd7);
    send(OP_DIVU, 32'd100, 32'd7, 0, 0, 5'd10, "R7 divu", 32'd14);
    // R8
    send(OP_DIV, 32'hFFFF_FFF9, 32'd2, 0, 0, 5'd11, "R8 div trunc", 32'hFFFF_FFFD);
    send(OP_DIV, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 5'd11, "R8 div overflow", 32'h8000_0000);
    send(OP_DIV, 32'd9, 32'd0, 0, 0, 5'd11, "R8 div by zero", 32'd9);
    // R9
    send(OP_ADD, 32'd1, 32'd1, 0, 0, 5'd0, "R9 dest zero", 32'd2);
    drain();

    // R11: latency of a single-cycle op and of a divide
    send(OP_ADD, 32'd1, 32'd2, 0, 0, 5'd1, "R11 add", 32'd3);
    n = 0;
    @(negedge clk);
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    check("R11 alu latency", 32'(n), 32'd0);
    drain();
    send(OP_DIVU, 32'd50, 32'd5, 0, 0, 5'd1, "R11 divu", 32'd10);
    n = 0;
    @(negedge clk);
    while (!out_valid && n < 100) begin
      if (n == 5) check("R10 in_ready low in divide", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
      n++;
    end
    check("R11 divide latency", 32'(n), 32'd33);
    drain();

    // random stream under back-pressure
    rdy_rand = 1'b1;
    for (int i = 0; i < 400; i++) begin
      exu_op_e op;
      op = exu_op_e'($urandom_range(0, OP_COUNT - 1));
      send_m(op, pick(), pick(), 5'($urandom), 16'($urandom), 5'($urandom_range(0, 31)));
    end
    drain();
    rdy_rand = 1'b0;
    drain();
    check("R10 scoreboard empty", 32'(sb.size()), 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule